// File: doc/BRIEF.md
# Microsecond Counter with Compare Interrupts

This block is a memory-mapped system timer. A prescaler divides the system clock down to a one-cycle tick at 1 MHz, and a 64-bit free-running counter advances on each tick. Software reads the counter through two 32-bit words. Reading the low word captures the high word at the same moment, so a following read of the high word gives a value that is consistent with the low word.

Four compare channels each hold a 32-bit target. A channel matches on the tick where the counter's low 32 bits step onto its target. A match sets that channel's status flag and raises its own interrupt line. The line stays high until software writes a one to the flag's bit in the status register. Bits written as zero leave their flags as they are. All accesses are aligned 32-bit words in a 32-byte window. Unmapped or misaligned offsets read as zero, and writes to them are dropped.

Top module: `usec_cmp_timer`

## Requirements
- R1: After reset the status register, all four compare registers and the counter read as zero, and every interrupt line is low.
- R2: The counter increments by exactly one every TICK_DIV system clock cycles, so two low-word reads taken K·TICK_DIV cycles apart differ by K.
- R3: Read data appears on `rd_data` one cycle after the read request. Offset 0x04 returns counter bits 31:0. Offset 0x08 returns counter bits 63:32 as they were captured at the most recent read of 0x04.
- R4: Writes to offsets 0x04 and 0x08 have no effect on the counter.
- R5: Compare channel n (n = 0..3) is written and read back at offset 0x0C + 4·n.
- R6: When the counter's low word steps onto compare n, status bit n and `irq[n]` go to 1 and stay at 1 until they are cleared.
- R7: A compare value that the low word has already passed does not raise the flag before the counter reaches that value again.
- R8: A write to offset 0x00 clears every status bit written as 1 and drops the matching interrupt line. Bits written as 0 keep their value.
- R9: Rewriting a compare register does not clear a flag that is already pending.
- R10: A read of offset 0x1C, or of any address with bits 1:0 non-zero, returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 5 | Byte offset within the 32-byte window |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 4 | One interrupt line per compare channel |

## Verification
The register path is tried with a table of distinct compare values on every channel. The table mixes writes to read-only, unmapped and misaligned offsets, so a decode that aliases one offset onto another shows up as a changed read-back. Matching is tried with a target a few ticks ahead, which must fire, and with a target already passed, which must not, so a comparison against the wrong counter phase is detected. Flag clearing is tried with a mask that covers only one of two pending channels, which separates write-one-to-clear from clear-all. A compare rewrite while a flag is pending is also tried.

// File: rtl/utm_pkg.sv
// Package: shared constants and the register index type for the microsecond timer.
// Assumes a 32-bit word bus with byte addressing inside a 32-byte window.
package utm_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 64;
    localparam int NUM_CH   = 4;
    localparam int ADDR_W   = 5;

    // Word index = byte offset >> 2
    typedef enum logic [2:0] {
        IDX_STATUS = 3'd0,
        IDX_CNT_LO = 3'd1,
        IDX_CNT_HI = 3'd2,
        IDX_CMP0   = 3'd3,
        IDX_CMP1   = 3'd4,
        IDX_CMP2   = 3'd5,
        IDX_CMP3   = 3'd6,
        IDX_NONE   = 3'd7
    } reg_idx_t;
endpackage

// File: rtl/utm_tick_gen.sv
// Module: utm_tick_gen
// Divides the system clock into a single-cycle tick enable every DIV cycles.
// Assumes DIV >= 1; with DIV == 1 the tick is high on every cycle.
module utm_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    generate
        if (DIV > 1) begin : g_div
            logic [PW-1:0] phase_q;

            // Purpose: count system clocks modulo DIV
            always_ff @(posedge clk) begin
                if (!rst_n)               phase_q <= '0;
                else if (phase_q == LAST) phase_q <= '0;
                else                      phase_q <= phase_q + 1'b1;
            end

            assign tick = (phase_q == LAST);

            // A tick never lasts more than one cycle (R2)
            p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/utm_counter.sv
// Module: utm_counter
// Free-running wide counter advancing by one on each tick enable.
// Assumes wrap-around at 2**W is acceptable; also exports the next value for match logic.
module utm_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] count_next
);
    assign count_next = count + 1'b1;

    // Purpose: hold the running count and step it on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count_next;
    end

    // Counter holds between ticks (R2)
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // Counter advances by one on a tick (R2)
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/utm_cmp_chan.sv
// Module: utm_cmp_chan
// One compare channel: a target register and a sticky match flag.
// Assumes the flag is set on the tick where the counter's low word steps onto the
// target; the set takes priority over a clear in the same cycle.
module utm_cmp_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] lo_next,
    input  logic [W-1:0] lo_now,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         flag_clr,
    output logic [W-1:0] cmp_q,
    output logic         flag_q
);
    logic hit;
    assign hit = tick && (lo_next == cmp_q);

    // Purpose: store the compare target written by software
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    // Purpose: sticky match flag, set by a hit and cleared by a write of one
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (hit)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // A flag rises only where the counter now equals the target it had (R6)
    p_rise_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(tick) && (lo_now == $past(cmp_q))));
    // A pending flag stays set without a clear (R6, R9)
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);
    // A clear without a simultaneous hit drops the flag (R8)
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !tick) |=> !flag_q);
endmodule

// File: rtl/usec_cmp_timer.sv
// Module: usec_cmp_timer
// Memory-mapped microsecond timer: prescaler, 64-bit counter, four compare
// channels with write-one-to-clear flags and one interrupt line each.
// Assumes aligned 32-bit accesses; misaligned or unmapped offsets read zero
// and ignore writes. Read data is registered (one cycle latency).
module usec_cmp_timer #(
    parameter int TICK_DIV = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic [31:0] rd_data,
    output logic [3:0]  irq
);
    import utm_pkg::*;

    localparam int HALF = CNT_W / 2;

    logic                tick;
    logic [CNT_W-1:0]    count, count_next;
    logic [WORD_W-1:0]   cmp_val [NUM_CH];
    logic [NUM_CH-1:0]   flags;
    logic [NUM_CH-1:0]   cmp_we;
    logic [NUM_CH-1:0]   clr_mask;
    logic [WORD_W-1:0]   hi_snap;
    logic [WORD_W-1:0]   rd_mux;
    reg_idx_t            idx;
    logic                rd_req, wr_req;

    utm_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    utm_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .count      (count),
        .count_next (count_next)
    );

    // Purpose: map the byte offset to a register index, misaligned -> none
    always_comb begin
        if (req_addr[1:0] != 2'b00) idx = IDX_NONE;
        else                        idx = reg_idx_t'(req_addr[4:2]);
    end

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid &&  req_write;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            assign cmp_we[ch]   = wr_req && (idx == reg_idx_t'(int'(IDX_CMP0) + ch));
            assign clr_mask[ch] = wr_req && (idx == IDX_STATUS) && req_wdata[ch];

            utm_cmp_chan #(.W(WORD_W)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .lo_next   (count_next[WORD_W-1:0]),
                .lo_now    (count[WORD_W-1:0]),
                .cmp_we    (cmp_we[ch]),
                .cmp_wdata (req_wdata),
                .flag_clr  (clr_mask[ch]),
                .cmp_q     (cmp_val[ch]),
                .flag_q    (flags[ch])
            );
        end
    endgenerate

    assign irq = flags;

    // Purpose: select the read value for the addressed register
    always_comb begin
        rd_mux = '0;
        case (idx)
            IDX_STATUS: rd_mux = {{(WORD_W-NUM_CH){1'b0}}, flags};
            IDX_CNT_LO: rd_mux = count[WORD_W-1:0];
            IDX_CNT_HI: rd_mux = hi_snap;
            IDX_CMP0:   rd_mux = cmp_val[0];
            IDX_CMP1:   rd_mux = cmp_val[1];
            IDX_CMP2:   rd_mux = cmp_val[2];
            IDX_CMP3:   rd_mux = cmp_val[3];
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: capture the high half alongside every low-word read
    always_ff @(posedge clk) begin
        if (!rst_n)                           hi_snap <= '0;
        else if (rd_req && idx == IDX_CNT_LO) hi_snap <= count[CNT_W-1:HALF];
    end

    // Purpose: register read data one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_mux;
    end

    // Unmapped or misaligned reads return zero (R10)
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (req_addr[1:0] != 2'b00 || req_addr[4:2] == 3'd7)) |=> (rd_data == '0));
    // Interrupt lines only rise on a tick (R6)
    p_irq_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != $past(irq) && (irq & ~$past(irq)) != '0) |-> $past(tick));
endmodule

// File: tb/test_usec_cmp_timer.sv
module test_usec_cmp_timer;
    localparam int DIV = 5;
    localparam int NV  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usec_cmp_timer #(.TICK_DIV(DIV)) i_usec_cmp_timer (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_data (rd_data), .irq (irq)
    );

    // Vector: {write, addr[4:0], data[31:0] (write data or expected read), req[3:0]}
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 5'h0C, 32'hF000_0000, 4'd5},
        {1'b1, 5'h10, 32'hF000_0011, 4'd5},
        {1'b1, 5'h14, 32'hF000_0222, 4'd5},
        {1'b1, 5'h18, 32'hF000_3333, 4'd5},
        {1'b0, 5'h0C, 32'hF000_0000, 4'd5},
        {1'b0, 5'h10, 32'hF000_0011, 4'd5},
        {1'b0, 5'h14, 32'hF000_0222, 4'd5},
        {1'b0, 5'h18, 32'hF000_3333, 4'd5},
        {1'b1, 5'h1C, 32'hAAAA_5555, 4'd10},
        {1'b1, 5'h0E, 32'h1234_5678, 4'd10},
        {1'b1, 5'h11, 32'h0BAD_0BAD, 4'd10},
        {1'b0, 5'h0C, 32'hF000_0000, 4'd10},
        {1'b0, 5'h10, 32'hF000_0011, 4'd10},
        {1'b0, 5'h1C, 32'h0000_0000, 4'd10},
        {1'b0, 5'h0F, 32'h0000_0000, 4'd10},
        {1'b0, 5'h00, 32'h0000_0000, 4'd8}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the capture edge
    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        v = rd_data;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            summary();
        end
    end

    initial begin
        logic [31:0] v, v2, lo;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(irq == 4'h0, "R1 irq", {28'h0, irq}, 32'h0);
        rd(5'h00, v); check(v == 0, "R1 status", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(5'(12 + 4 * i), v); check(v == 0, "R1 compare", v, 0);
        end
        rd(5'h04, v); check(v < 3, "R1 counter low", v, 32'd2);

        // Table walk: R5 compare access, R10 unmapped/misaligned, R8 status idle
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][41]) wr(VEC[i][40:36], VEC[i][35:4]);
            else begin
                rd(VEC[i][40:36], v);
                check(v == VEC[i][35:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i),
                      v, VEC[i][35:4]);
            end
        end

        // R4: writes to counter words leave the counter alone
        wr(5'h04, 32'h8000_0000);
        wr(5'h08, 32'h0000_0077);
        rd(5'h04, v); check(v < 32'd1000, "R4 low after write", v, 32'd0);
        // R3: high word coherent with the low read (zero this early)
        rd(5'h08, v); check(v == 0, "R3 high snapshot", v, 0);

        // R2: two low reads exactly 10*DIV cycles apart differ by 10
        rd(5'h04, v);
        repeat (10 * DIV - 1) @(negedge clk);
        rd(5'h04, v2);
        check(v2 - v == 10, "R2 tick rate", v2 - v, 10);

        // R6: targets a few ticks ahead on channels 1 and 2
        rd(5'h04, lo);
        wr(5'h10, lo + 3);
        wr(5'h14, lo + 4);
        // R7: channel 0 target already passed
        wr(5'h0C, lo - 1);
        check(irq == 4'h0, "R6 no early irq", {28'h0, irq}, 0);
        repeat (6 * DIV) @(negedge clk);
        check(irq == 4'b0110, "R6 irq after match", {28'h0, irq}, 32'h6);
        check(irq[0] == 1'b0, "R7 passed target silent", {31'h0, irq[0]}, 0);
        rd(5'h00, v); check(v == 32'h6, "R6 status bits", v, 32'h6);
        repeat (3 * DIV) @(negedge clk);
        check(irq == 4'b0110, "R6 flags sticky", {28'h0, irq}, 32'h6);

        // R9: rewriting a compare keeps the pending flag
        wr(5'h14, 32'hFFFF_0000);
        check(irq[2] == 1'b1, "R9 flag kept", {31'h0, irq[2]}, 1);

        // R8: clear only channel 1
        wr(5'h00, 32'h0000_0002);
        check(irq == 4'b0100, "R8 partial clear irq", {28'h0, irq}, 32'h4);
        rd(5'h00, v); check(v == 32'h4, "R8 partial clear status", v, 32'h4);
        wr(5'h00, 32'h0000_000F);
        rd(5'h00, v); check(v == 0, "R8 full clear", v, 0);
        check(irq == 4'h0, "R8 irq low", {28'h0, irq}, 0);

        // R1: reset again clears compares and flags
        wr(5'h10, lo + 30);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(5'h10, v); check(v == 0, "R1 compare after reset", v, 0);
        rd(5'h04, v); check(v < 2, "R1 counter after reset", v, 32'd1);

        done = 1'b1;
        summary();
    end
endmodule